// File: doc/BRIEF.md
# Arithmetic Execute Unit with Loop Stage Counter

This unit executes the arithmetic instructions of a small sequencing coprocessor. It owns four 16-bit general registers, a zero flag and an overflow flag that describe the most recent arithmetic result, and an independent 8-bit stage counter used to count loop passes. A decoder upstream presents a 32-bit instruction word together with an execute strobe. The unit performs the selected operation and writes the result back in a single clock cycle.

Three instruction forms are accepted. In the register form, both operands come from registers. In the immediate form, the second operand comes from a 16-bit literal. The stage form adds an 8-bit literal to the stage counter, subtracts it from the counter, or clears the counter. The register file, both flags and the counter are driven straight onto output ports, so that a neighbouring branch unit can test them. That unit evaluates conditional jumps on the zero and overflow flags, and compares the stage counter against thresholds.

Top module: `alu_stage_exec`

## Requirements
- R1: After reset is asserted, every register, both flags and the stage counter read zero.
- R2: An instruction takes effect only when exec_i is high and insn_i[31:28] equals 7. Its result appears on the outputs after the next rising clock edge. Any other instruction word, or exec_i low, leaves all state unchanged.
- R3: insn_i[27:26]=0 selects the register form: destination [1:0], operand A [3:2], operand B [5:4]. The operation select insn_i[24:21] encodes 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left and 6 shift right.
- R4: insn_i[27:26]=1 selects the immediate form. Operand B is insn_i[19:4], and destination and operand A use the same fields as the register form.
- R5: After an add, the overflow flag holds the carry out of bit 15. After a subtract, it holds the borrow, which is 1 exactly when A is less than B as unsigned numbers.
- R6: AND, OR, move and both shifts clear the overflow flag. In the register form, move copies operand A into the destination. In the immediate form, move copies the immediate.
- R7: Shifts are logical with zero fill. The shift distance is the low 4 bits of operand B.
- R8: After every arithmetic operation that executes, the zero flag is 1 exactly when the 16-bit result written to the destination is zero.
- R9: insn_i[27:26]=2 acts on the stage counter with the literal insn_i[11:4]. Select 0 adds the literal and select 1 subtracts it, both wrapping modulo 256. Select 2 clears the counter.
- R10: Stage-form instructions leave the registers and both flags unchanged. Register-form and immediate-form instructions leave the stage counter unchanged.
- R11: The following instructions change nothing: selects 7 to 15 in the register and immediate forms, selects 3 to 15 in the stage form, and form 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the presented instruction |
| insn_i | input | 32 | Decoded instruction word |
| regs_o | output | 64 | Register contents, register n in bits [16n+15:16n] |
| zero_o | output | 1 | Last arithmetic result was zero |
| ovf_o | output | 1 | Carry or borrow of the last add or subtract |
| stage_o | output | 8 | Stage counter value |

## Verification
Every piece of state in this unit is visible on a port. A wrong write-back, flag update or counter step therefore shows on the outputs one clock edge after the instruction that caused it. The scoreboard compares all outputs after each issued instruction, including no-op and ignored instructions, so a stray write is caught in the same cycle. It cannot be hidden until some later read. Flag errors that only matter later are exposed by placing stage and no-op instructions directly after flag-setting operations, and checking that the flags are unchanged.

// File: rtl/alu_stage_pkg.sv
package alu_stage_pkg;

  localparam logic [3:0] OPC_ALU = 4'd7;

  typedef enum logic [1:0] {
    FORM_REG   = 2'd0,
    FORM_IMM   = 2'd1,
    FORM_STAGE = 2'd2,
    FORM_RSVD  = 2'd3
  } form_e;

  typedef enum logic [3:0] {
    SEL_ADD = 4'd0,
    SEL_SUB = 4'd1,
    SEL_AND = 4'd2,
    SEL_OR  = 4'd3,
    SEL_MOV = 4'd4,
    SEL_LSH = 4'd5,
    SEL_RSH = 4'd6
  } alu_sel_e;

  typedef enum logic [3:0] {
    STG_INC = 4'd0,
    STG_DEC = 4'd1,
    STG_CLR = 4'd2
  } stage_sel_e;

endpackage

// File: rtl/alu_stage_regfile.sv
module alu_stage_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RIDX_W-1:0]      waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [RIDX_W-1:0]      raddr_a_i,
  input  logic [RIDX_W-1:0]      raddr_b_i,
  output logic [DATA_W-1:0]      rdata_a_o,
  output logic [DATA_W-1:0]      rdata_b_o,
  output logic [NREG*DATA_W-1:0] regs_o
);

  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[i] <= '0;
      else if (we_i && waddr_i == RIDX_W'(i)) mem_q[i] <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/alu_stage_core.sv
module alu_stage_core
  import alu_stage_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [3:0]        sel_i,
  input  logic              imm_form_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);

  logic [DATA_W:0]   wide;
  logic [SH_W-1:0]   sh;

  assign sh = b_i[SH_W-1:0];

  always_comb begin
    valid_o = 1'b1;
    ovf_o   = 1'b0;
    wide    = '0;
    res_o   = '0;
    case (sel_i)
      SEL_ADD: begin
        wide  = {1'b0, a_i} + {1'b0, b_i};
        res_o = wide[DATA_W-1:0];
        ovf_o = wide[DATA_W];
      end
      SEL_SUB: begin
        wide  = {1'b0, a_i} - {1'b0, b_i};
        res_o = wide[DATA_W-1:0];
        ovf_o = wide[DATA_W];
      end
      SEL_AND: res_o = a_i & b_i;
      SEL_OR:  res_o = a_i | b_i;
      SEL_MOV: res_o = imm_form_i ? b_i : a_i;
      SEL_LSH: res_o = a_i << sh;
      SEL_RSH: res_o = a_i >> sh;
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_stage_counter.sv
module alu_stage_counter
  import alu_stage_pkg::*;
#(
  parameter int STAGE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [3:0]         sel_i,
  input  logic [STAGE_W-1:0] imm_i,
  output logic [STAGE_W-1:0] cnt_o
);

  logic [STAGE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      case (sel_i)
        STG_INC: cnt_d = cnt_q + imm_i;
        STG_DEC: cnt_d = cnt_q - imm_i;
        STG_CLR: cnt_d = '0;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/alu_stage_exec.sv
module alu_stage_exec
  import alu_stage_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int STAGE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   exec_i,
  input  logic [31:0]            insn_i,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   zero_o,
  output logic                   ovf_o,
  output logic [STAGE_W-1:0]     stage_o
);

  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 16;

  logic              op_hit;
  form_e             form;
  logic [3:0]        sel;
  logic [RIDX_W-1:0] rd, ra, rb;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] a_val, b_reg, b_val, res;
  logic              core_valid, core_ovf, alu_go, stage_go;
  logic              zero_q, ovf_q;
  logic              unused_bits;

  assign op_hit = exec_i && (insn_i[31:28] == OPC_ALU);
  assign form   = form_e'(insn_i[27:26]);
  assign sel    = insn_i[24:21];
  assign rd     = insn_i[1:0];
  assign ra     = insn_i[3:2];
  assign rb     = insn_i[5:4];
  assign imm    = insn_i[19:4];
  assign unused_bits = ^{insn_i[25], insn_i[20]};

  assign b_val  = (form == FORM_IMM) ? DATA_W'(imm) : b_reg;

  alu_stage_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (alu_go),
    .waddr_i   (rd),
    .wdata_i   (res),
    .raddr_a_i (ra),
    .raddr_b_i (rb),
    .rdata_a_o (a_val),
    .rdata_b_o (b_reg),
    .regs_o    (regs_o)
  );

  alu_stage_core #(.DATA_W(DATA_W)) u_core (
    .sel_i      (sel),
    .imm_form_i (form == FORM_IMM),
    .a_i        (a_val),
    .b_i        (b_val),
    .valid_o    (core_valid),
    .res_o      (res),
    .ovf_o      (core_ovf)
  );

  assign alu_go   = op_hit && (form == FORM_REG || form == FORM_IMM) && core_valid;
  assign stage_go = op_hit && (form == FORM_STAGE);

  alu_stage_counter #(.STAGE_W(STAGE_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (stage_go),
    .sel_i  (sel),
    .imm_i  (insn_i[4 +: STAGE_W]),
    .cnt_o  (stage_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (alu_go) begin
      zero_q <= (res == '0);
      ovf_q  <= core_ovf;
    end
  end

  assign zero_o = zero_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/alu_stage_exec_chk.sv
module alu_stage_exec_chk #(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int STAGE_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   exec_i,
  input logic [31:0]            insn_i,
  input logic [NREG*DATA_W-1:0] regs_o,
  input logic                   zero_o,
  input logic                   ovf_o,
  input logic [STAGE_W-1:0]     stage_o
);

  logic       hit, alu_form, stage_form, alu_valid;
  logic [3:0] sel;
  logic       fire_q;
  logic [1:0] dst_q;
  logic [DATA_W-1:0] dst_val;

  assign hit        = exec_i && insn_i[31:28] == 4'd7;
  assign sel        = insn_i[24:21];
  assign alu_form   = insn_i[27:26] == 2'd0 || insn_i[27:26] == 2'd1;
  assign stage_form = insn_i[27:26] == 2'd2;
  assign alu_valid  = hit && alu_form && sel <= 4'd6;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
      dst_q  <= '0;
    end else begin
      fire_q <= alu_valid;
      dst_q  <= insn_i[1:0];
    end
  end

  assign dst_val = regs_o[dst_q*DATA_W +: DATA_W];

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> ($stable(regs_o) && $stable(zero_o) && $stable(ovf_o) && $stable(stage_o)));

  // R6
  logic_ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid && sel >= 4'd2) |=> !ovf_o);

  // R8
  zero_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> (zero_o == (dst_val == '0)));

  // R9
  stage_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && stage_form && sel == 4'd2) |=> stage_o == '0);

  // R10
  stage_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && stage_form) |=> ($stable(zero_o) && $stable(ovf_o) && $stable(regs_o)));

  // R10
  alu_keeps_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && alu_form) |=> $stable(stage_o));

  // R11
  bad_sel_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && alu_form && sel > 4'd6) |=> ($stable(regs_o) && $stable(zero_o) && $stable(ovf_o)));

endmodule

bind alu_stage_exec alu_stage_exec_chk #(
  .DATA_W(DATA_W), .NREG(NREG), .STAGE_W(STAGE_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec_i),
  .insn_i  (insn_i),
  .regs_o  (regs_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o),
  .stage_o (stage_o)
);

// File: tb/tb_alu_stage_exec.sv
module tb_alu_stage_exec;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] regs_o;
  logic        zero_o, ovf_o;
  logic [7:0]  stage_o;

  int checks = 0;
  int failures = 0;
  logic chk_pend = 1'b0;
  logic done = 1'b0;

  always #2 clk_i = ~clk_i;

  alu_stage_exec dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .insn_i(insn_i),
    .regs_o(regs_o), .zero_o(zero_o), .ovf_o(ovf_o), .stage_o(stage_o)
  );

  typedef struct {
    logic [63:0] regs;
    logic        z;
    logic        o;
    logic [7:0]  st;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  logic [15:0] m_r [4];
  logic        m_z = 1'b0, m_o = 1'b0;
  logic [7:0]  m_st = '0;

  function automatic logic [31:0] enc_reg(input logic [3:0] sel, input logic [1:0] d, a, b);
    return {4'd7, 2'd0, 1'b0, sel, 15'd0, b, a, d};
  endfunction

  function automatic logic [31:0] enc_imm(input logic [3:0] sel, input logic [1:0] d, a, input logic [15:0] imm);
    return {4'd7, 2'd1, 1'b0, sel, 1'b0, imm, a, d};
  endfunction

  function automatic logic [31:0] enc_stg(input logic [3:0] sel, input logic [7:0] imm);
    return {4'd7, 2'd2, 1'b0, sel, 9'd0, imm, 4'd0};
  endfunction

  // expected behaviour from the requirements
  task automatic model(input logic [31:0] w, input logic ex);
    logic [1:0]  form = w[27:26];
    logic [3:0]  sel  = w[24:21];
    logic [15:0] a    = m_r[w[3:2]];
    logic [15:0] b    = (form == 2'd1) ? w[19:4] : m_r[w[5:4]];
    logic [16:0] t;
    logic [15:0] r = '0;
    logic        o = 1'b0;
    logic        ok = 1'b1;
    if (!ex || w[31:28] != 4'd7) return;
    if (form == 2'd2) begin
      if (sel == 4'd0) m_st = m_st + w[11:4];
      else if (sel == 4'd1) m_st = m_st - w[11:4];
      else if (sel == 4'd2) m_st = '0;
      return;
    end
    if (form == 2'd3) return;
    case (sel)
      4'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[15:0]; o = t[16]; end
      4'd1: begin o = a < b; r = a - b; end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = (form == 2'd1) ? b : a;
      4'd5: r = a << b[3:0];
      4'd6: r = a >> b[3:0];
      default: ok = 1'b0;
    endcase
    if (!ok) return;
    m_r[w[1:0]] = r;
    m_z = (r == 16'd0);
    m_o = o;
  endtask

  task automatic issue(input logic [31:0] w, input logic ex, input string tag);
    exp_t e;
    @(negedge clk_i);
    model(w, ex);
    e.regs = {m_r[3], m_r[2], m_r[1], m_r[0]};
    e.z = m_z; e.o = m_o; e.st = m_st; e.tag = tag;
    sb_q.push_back(e);
    insn_i = w;
    exec_i = ex;
    chk_pend = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    exec_i = 1'b0;
    chk_pend = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (chk_pend) begin
        exp_t e;
        #1;
        e = sb_q.pop_front();
        checks++;
        if (regs_o !== e.regs || zero_o !== e.z || ovf_o !== e.o || stage_o !== e.st) begin
          failures++;
          $display("FAIL %s: regs=%h z=%b o=%b st=%0d expected regs=%h z=%b o=%b st=%0d",
                   e.tag, regs_o, zero_o, ovf_o, stage_o, e.regs, e.z, e.o, e.st);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (regs_o !== '0 || zero_o !== 1'b0 || ovf_o !== 1'b0 || stage_o !== '0) begin
      failures++;
      $display("FAIL R1 reset: regs=%h z=%b o=%b st=%0d expected all zero",
               regs_o, zero_o, ovf_o, stage_o);
    end
    issue(enc_imm(4'd0, 2'd0, 2'd0, 16'h1234), 1'b1, "R4 imm add");
    issue(enc_imm(4'd0, 2'd1, 2'd0, 16'hEDCC), 1'b1, "R5 R8 carry to zero");
    issue(enc_imm(4'd4, 2'd2, 2'd1, 16'h8001), 1'b1, "R6 imm move");
    issue(enc_reg(4'd0, 2'd3, 2'd0, 2'd2), 1'b1, "R3 reg add");
    issue(enc_reg(4'd1, 2'd1, 2'd0, 2'd2), 1'b1, "R5 borrow");
    issue(enc_reg(4'd2, 2'd1, 2'd3, 2'd2), 1'b1, "R3 R6 and");
    issue(enc_reg(4'd3, 2'd1, 2'd0, 2'd2), 1'b1, "R3 or");
    issue(enc_reg(4'd4, 2'd1, 2'd0, 2'd3), 1'b1, "R6 reg move");
    issue(enc_imm(4'd5, 2'd1, 2'd2, 16'h0013), 1'b1, "R7 lsh low bits");
    issue(enc_imm(4'd6, 2'd1, 2'd2, 16'h000F), 1'b1, "R7 rsh 15");
    issue(enc_reg(4'd6, 2'd1, 2'd0, 2'd3), 1'b1, "R7 reg rsh");
    issue(enc_imm(4'd1, 2'd1, 2'd0, 16'h1234), 1'b1, "R5 R8 equal sub");
    issue(enc_stg(4'd0, 8'd200), 1'b1, "R9 stage add");
    issue(enc_stg(4'd0, 8'd100), 1'b1, "R9 R10 stage wrap up");
    issue(enc_imm(4'd0, 2'd2, 2'd2, 16'h8000), 1'b1, "R5 set carry");
    issue(enc_stg(4'd1, 8'd50), 1'b1, "R9 R10 stage wrap down");
    issue(enc_stg(4'd5, 8'd9), 1'b1, "R11 stage bad sel");
    issue(enc_stg(4'd2, 8'd77), 1'b1, "R9 stage clear");
    issue(enc_imm(4'd7, 2'd0, 2'd0, 16'h0000), 1'b1, "R11 sel 7");
    issue(enc_reg(4'd15, 2'd0, 2'd1, 2'd1), 1'b1, "R11 sel 15");
    issue({4'd7, 2'd3, 26'h3FFFFFF}, 1'b1, "R11 form 3");
    issue(enc_imm(4'd0, 2'd3, 2'd3, 16'h0001), 1'b0, "R2 exec low");
    issue({4'd6, enc_imm(4'd4, 2'd3, 2'd3, 16'h0000)}[31:0] & 32'h6FFFFFFF, 1'b1, "R2 wrong opcode");
    issue(enc_stg(4'd0, 8'd3), 1'b1, "R9 stage after clear");
    issue(enc_imm(4'd3, 2'd0, 2'd2, 16'h0000), 1'b1, "R6 R10 or clears ovf");
    idle();
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule